// File: doc/BRIEF.md
# Bit-Serial CRC-16 Engine for Binary Command Frames

This block computes the 16-bit cyclic redundancy check carried at the end of binary serial command frames. A byte source hands it one byte at a time over a valid/ready handshake. A start-of-frame qualifier travels with the first byte and reloads the register. An end-of-frame qualifier travels with the final byte. Each accepted byte is folded into the low half of the register. The register then takes eight single-bit steps, one per clock. Each step is a right shift that brings in a zero at the top. When the bit shifted out was a one, the constant A001 (hex) is also XORed in. The input is closed while these steps run.

On the transmit side, the result appears as two byte outputs. The low byte goes onto the line first and the high byte follows. On the receive side, the frame is run in check mode with the two received CRC bytes appended, low byte first. A correct frame leaves the register at zero. The block flags this on a dedicated output when the frame completes. Byte reception, idle-line timing and message decoding are handled elsewhere.

Top module: `crc16_serial_engine`

## Requirements
- R1: After reset, in_ready is 1, frame_done is 0, crc_ok is 0, and crc_lo and crc_hi both read FF hex.
- R2: A byte accepted with sof set starts from FFFF: the register becomes FFFF with the byte XORed into bits 7:0. A byte accepted without sof is XORed into bits 7:0 of the current register. A sof byte received in the middle of a frame discards all earlier bytes.
- R3: During a step where the register's bit 0 is 0, the register shifts right by one and bit 15 becomes 0.
- R4: During a step where the register's bit 0 is 1, the register shifts right by one and is then XORed with A001 hex, so bit 15 becomes 1.
- R5: Each accepted byte takes exactly eight steps. in_ready is 0 for the eight cycles after the accepting edge and returns to 1 in the ninth, so bytes are taken at most once every nine clocks.
- R6: A byte offered while in_ready is 0 is not taken and has no effect on the result.
- R7: crc_lo carries register bits 7:0, which are sent first, and crc_hi carries bits 15:8. The frame 01 03 21 02 00 02 (hex) gives crc_lo = 6F and crc_hi = F7.
- R8: frame_done is high for exactly one cycle. That cycle immediately follows the edge that performs the eighth step of a byte accepted with eof. A byte without eof raises no frame_done.
- R9: check_mode is sampled with each sof byte. When a check-mode frame completes, crc_ok becomes 1 exactly when the register is 0000. crc_ok stays 0 for frames run in normal mode, and any newly accepted byte clears it.
- R10: A new sof byte can be accepted in the same cycle that frame_done is high. The finished frame's result and crc_ok remain readable in that cycle, and the new frame starts clean.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Offered byte |
| sof | input | 1 | Offered byte opens a new frame |
| eof | input | 1 | Offered byte closes the frame |
| check_mode | input | 1 | Frame is a receive check with the CRC bytes appended (taken with sof byte) |
| in_ready | output | 1 | Engine can take a byte this cycle |
| crc_lo | output | 8 | Register bits 7:0, first CRC byte on the line |
| crc_hi | output | 8 | Register bits 15:8, second CRC byte on the line |
| frame_done | output | 1 | One-cycle pulse after the final byte's last step |
| crc_ok | output | 1 | Check-mode frame left a zero residue |

## Verification
The completion pulse of one frame and the acceptance of the next frame's opening byte can fall in the same cycle. This happens because in_ready reopens exactly when frame_done rises. The bench provokes this overlap by ending a check-mode frame and offering a new sof byte in the cycle where frame_done is high. In that cycle it confirms that the zero residue and crc_ok are still visible. On the following cycle it confirms that the pulse has dropped, crc_ok has cleared and the engine is busy. It then completes the new frame and compares the result with a bench-side bitwise model, which shows that no state from the previous frame leaked into it.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_SHIFT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/crc16_bitstep.sv
// One reflected division step: shift right with zero fill, fold in the
// polynomial when the bit leaving at the bottom was set.
module crc16_bitstep #(
    parameter int          CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'hA001
) (
    input  logic [CRC_W-1:0] crc_in,
    output logic [CRC_W-1:0] crc_out
);

    logic [CRC_W-1:0] shifted;

    always_comb begin
        shifted = {1'b0, crc_in[CRC_W-1:1]};
        crc_out = crc_in[0] ? (shifted ^ POLY) : shifted;
    end

endmodule

// File: rtl/crc16_seq.sv
// Handshake and step sequencer: owns acceptance, the step counter and the
// frame-level flags (eof carried with a byte, sampled mode, done, ok).
module crc16_seq #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic sof,
    input  logic eof,
    input  logic check_mode,
    input  logic zero_next,
    output logic in_ready,
    output logic accept,
    output logic shifting,
    output logic frame_done,
    output logic crc_ok
);
    import crc16_pkg::*;

    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             eof_held;
        logic             mode;
        logic             done;
        logic             ok;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        in_ready   = (seq_q.state == SEQ_IDLE);
        shifting   = (seq_q.state == SEQ_SHIFT);
        accept     = in_ready && in_valid;

        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (in_valid) begin
                    seq_d.state    = SEQ_SHIFT;
                    seq_d.cnt      = '0;
                    seq_d.eof_held = eof;
                    seq_d.ok       = 1'b0;
                    if (sof) begin
                        seq_d.mode = check_mode;
                    end
                end
            end
            SEQ_SHIFT: begin
                if (seq_q.cnt == LAST_STEP) begin
                    seq_d.state = SEQ_IDLE;
                    if (seq_q.eof_held) begin
                        seq_d.done = 1'b1;
                        seq_d.ok   = seq_q.mode && zero_next;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, cnt: '0, eof_held: 1'b0,
                       mode: 1'b0, done: 1'b0, ok: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign frame_done = seq_q.done;
    assign crc_ok     = seq_q.ok;

    // R5: the input closes on the edge after a byte is taken
    assert_ready_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8: the completion flag never lasts two cycles
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8: completion only follows a cycle of stepping
    assert_done_after_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> $past(shifting));

endmodule

// File: rtl/crc16_datapath.sv
// The CRC register: loads/merges an accepted byte, then steps once per clock.
module crc16_datapath #(
    parameter int               CRC_W  = 16,
    parameter int               BYTE_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 16'hA001,
    parameter logic [CRC_W-1:0] INIT   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              sof,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              shifting,
    output logic [CRC_W-1:0]  crc,
    output logic              zero_next
);

    localparam int PAD_W = CRC_W - BYTE_W;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } dp_t;

    dp_t              dp_d, dp_q;
    logic [CRC_W-1:0] stepped;
    logic [CRC_W-1:0] base;

    crc16_bitstep #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
        .crc_in (dp_q.crc),
        .crc_out(stepped)
    );

    always_comb begin
        dp_d = dp_q;
        base = sof ? INIT : dp_q.crc;
        if (accept) begin
            dp_d.crc = base ^ {{PAD_W{1'b0}}, in_data};
        end else if (shifting) begin
            dp_d.crc = stepped;
        end
        zero_next = (dp_d.crc == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '{crc: INIT};
        end else begin
            dp_q <= dp_d;
        end
    end

    assign crc = dp_q.crc;

    // R3: a clear bottom bit leaves a zero at the top after the step
    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shifting && !dp_q.crc[0]) |=> !dp_q.crc[CRC_W-1]);

    // R4: a set bottom bit folds in the constant, whose top bit is set
    assert_poly_fold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shifting && dp_q.crc[0]) |=> dp_q.crc[CRC_W-1] == POLY[CRC_W-1]);

    // R6: without acceptance or stepping the register holds
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !shifting) |=> $stable(dp_q.crc));

endmodule

// File: rtl/crc16_serial_engine.sv
module crc16_serial_engine #(
    parameter int                 CRC_W  = 16,
    parameter int                 BYTE_W = 8,
    parameter logic [CRC_W-1:0]   POLY   = 16'hA001,
    parameter logic [CRC_W-1:0]   INIT   = 16'hFFFF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [BYTE_W-1:0]         in_data,
    input  logic                      sof,
    input  logic                      eof,
    input  logic                      check_mode,
    output logic                      in_ready,
    output logic [BYTE_W-1:0]         crc_lo,
    output logic [CRC_W-BYTE_W-1:0]   crc_hi,
    output logic                      frame_done,
    output logic                      crc_ok
);

    logic             accept;
    logic             shifting;
    logic             zero_next;
    logic [CRC_W-1:0] crc;

    crc16_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sof       (sof),
        .eof       (eof),
        .check_mode(check_mode),
        .zero_next (zero_next),
        .in_ready  (in_ready),
        .accept    (accept),
        .shifting  (shifting),
        .frame_done(frame_done),
        .crc_ok    (crc_ok)
    );

    crc16_datapath #(
        .CRC_W (CRC_W),
        .BYTE_W(BYTE_W),
        .POLY  (POLY),
        .INIT  (INIT)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .sof      (sof),
        .in_data  (in_data),
        .shifting (shifting),
        .crc      (crc),
        .zero_next(zero_next)
    );

    assign crc_lo = crc[BYTE_W-1:0];
    assign crc_hi = crc[CRC_W-1:BYTE_W];

    // R9: a reported good residue means the register really is zero
    assert_ok_means_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> (crc_lo == '0 && crc_hi == '0));

    // R10: the busy period never overlaps a completion pulse
    assert_done_when_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> in_ready);

endmodule

// File: tb/crc16_serial_engine_bench.sv
`timescale 1ns/1ps
module crc16_serial_engine_bench;

    localparam int NV = 5;
    localparam int MAXB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       sof = 1'b0;
    logic       eof = 1'b0;
    logic       check_mode = 1'b0;
    logic       in_ready;
    logic [7:0] crc_lo;
    logic [7:0] crc_hi;
    logic       frame_done;
    logic       crc_ok;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    crc16_serial_engine u_crc16_serial_engine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .sof(sof), .eof(eof), .check_mode(check_mode), .in_ready(in_ready),
        .crc_lo(crc_lo), .crc_hi(crc_hi), .frame_done(frame_done), .crc_ok(crc_ok)
    );

    // stimulus table: byte count, then bytes
    localparam int VLEN [NV] = '{6, 6, 1, 3, 8};
    localparam logic [7:0] VBYTES [NV][MAXB] = '{
        '{8'h01, 8'h03, 8'h21, 8'h02, 8'h00, 8'h02, 8'h00, 8'h00},
        '{8'h11, 8'h06, 8'h00, 8'h01, 8'h00, 8'h03, 8'h00, 8'h00},
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'hFF, 8'h80, 8'h7E, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'hA5, 8'h5A, 8'h01, 8'hFE, 8'h33, 8'hC3, 8'h99, 8'h10}
    };

    logic [7:0] fbuf [12];
    int         flen;

    function automatic logic [15:0] model_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) begin
            if (r[0]) r = (r >> 1) ^ 16'hA001;
            else      r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [15:0] model_frame();
        logic [15:0] r;
        r = 16'hFFFF;
        for (int i = 0; i < flen; i++) r = model_byte(r, fbuf[i]);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // offer one byte; returns at the falling edge right after its acceptance
    task automatic send_byte(input logic [7:0] b, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; sof = s; eof = e;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; sof = 1'b0; eof = 1'b0; in_data = '0;
    endtask

    // sends fbuf; returns at the falling edge where frame_done must be high
    task automatic send_frame(input logic mode);
        check_mode = mode;
        for (int i = 0; i < flen; i++) send_byte(fbuf[i], i == 0, i == flen - 1);
        repeat (7) @(negedge clk);
        check("R8 no early done", {31'd0, frame_done}, 32'd0);
        @(negedge clk);
        check("R8 done after eighth step", {31'd0, frame_done}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] exp_crc;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", {31'd0, in_ready}, 32'd1);
        check("R1 done", {31'd0, frame_done}, 32'd0);
        check("R1 ok", {31'd0, crc_ok}, 32'd0);
        check("R1 crc", {16'd0, crc_hi, crc_lo}, 32'h0000FFFF);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: normal mode then check mode for each vector (R2 R3 R4 R7 R9)
        for (int v = 0; v < NV; v++) begin
            flen = VLEN[v];
            for (int i = 0; i < flen; i++) fbuf[i] = VBYTES[v][i];
            exp_crc = model_frame();
            send_frame(1'b0);
            check("R7 crc value", {16'd0, crc_hi, crc_lo}, {16'd0, exp_crc});
            check("R9 ok stays low in normal mode", {31'd0, crc_ok}, 32'd0);
            @(negedge clk);
            check("R8 done single cycle", {31'd0, frame_done}, 32'd0);
            fbuf[flen] = exp_crc[7:0];
            fbuf[flen+1] = exp_crc[15:8];
            flen = flen + 2;
            send_frame(1'b1);
            check("R9 ok on good frame", {31'd0, crc_ok}, 32'd1);
            check("R9 zero residue", {16'd0, crc_hi, crc_lo}, 32'd0);
        end

        // R7 literal vector, low byte first on the line
        flen = 6;
        for (int i = 0; i < 6; i++) fbuf[i] = VBYTES[0][i];
        send_frame(1'b0);
        check("R7 low byte 6F", {24'd0, crc_lo}, 32'h6F);
        check("R7 high byte F7", {24'd0, crc_hi}, 32'hF7);

        // R9 corrupted frame in check mode
        fbuf[6] = 8'h6F; fbuf[7] = 8'hF7; fbuf[2] = 8'h20; flen = 8;
        send_frame(1'b1);
        check("R9 ok low on bad frame", {31'd0, crc_ok}, 32'd0);
        // R9 good residue in normal mode is not flagged
        fbuf[2] = 8'h21;
        send_frame(1'b0);
        check("R9 residue zero normal", {16'd0, crc_hi, crc_lo}, 32'd0);
        check("R9 ok low normal mode", {31'd0, crc_ok}, 32'd0);

        // R5 throughput and R6 ignored byte while busy
        send_byte(8'h3C, 1'b1, 1'b0);
        check("R5 ready low after accept", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b1; in_data = 8'h55;
        begin
            int waited;
            waited = 0;
            while (!in_ready) begin
                @(negedge clk);
                waited++;
            end
            check("R5 ready back after eight steps", waited, 32'd8);
        end
        in_valid = 1'b0;
        check("R8 no done without eof", {31'd0, frame_done}, 32'd0);
        send_byte(8'hC3, 1'b0, 1'b1);
        repeat (8) @(negedge clk);
        exp_crc = model_byte(model_byte(16'hFFFF, 8'h3C), 8'hC3);
        check("R6 busy byte ignored", {16'd0, crc_hi, crc_lo}, {16'd0, exp_crc});

        // R2 sof mid-frame restarts
        send_byte(8'h12, 1'b1, 1'b0);
        send_byte(8'h34, 1'b1, 1'b1);
        repeat (8) @(negedge clk);
        check("R2 restart done", {31'd0, frame_done}, 32'd1);
        check("R2 restart value", {16'd0, crc_hi, crc_lo}, {16'd0, model_byte(16'hFFFF, 8'h34)});

        // R10 new frame opens in the cycle of completion
        flen = 3; fbuf[0] = 8'h07; fbuf[1] = 8'h9C; fbuf[2] = 8'hE2;
        check_mode = 1'b1;
        send_byte(8'h7E, 1'b1, 1'b0);
        send_byte(8'hFF, 1'b0, 1'b0);
        exp_crc = model_byte(model_byte(16'hFFFF, 8'h7E), 8'hFF);
        send_byte(exp_crc[7:0], 1'b0, 1'b0);
        send_byte(exp_crc[15:8], 1'b0, 1'b1);
        repeat (8) @(negedge clk);
        in_valid = 1'b1; in_data = 8'h07; sof = 1'b1; check_mode = 1'b0;
        check("R10 done in overlap cycle", {31'd0, frame_done}, 32'd1);
        check("R10 ok in overlap cycle", {31'd0, crc_ok}, 32'd1);
        check("R10 ready in overlap cycle", {31'd0, in_ready}, 32'd1);
        check("R10 residue in overlap cycle", {16'd0, crc_hi, crc_lo}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0; sof = 1'b0;
        check("R10 done dropped", {31'd0, frame_done}, 32'd0);
        check("R10 ok cleared", {31'd0, crc_ok}, 32'd0);
        check("R10 busy", {31'd0, in_ready}, 32'd0);
        send_byte(8'h9C, 1'b0, 1'b0);
        send_byte(8'hE2, 1'b0, 1'b1);
        repeat (8) @(negedge clk);
        check("R10 new frame value", {16'd0, crc_hi, crc_lo}, {16'd0, model_frame()});
        check("R10 new frame normal mode", {31'd0, crc_ok}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule